// File: doc/BRIEF.md
# Machine-Level Trap and Status Register Unit

This unit keeps the machine-level status and trap state of a small hart that runs mainly in its most privileged mode. It holds the global interrupt enable and its one-deep stack (the prior enable and the prior privilege). It also holds the trap vector base, the saved trap PC, the trap cause, the interrupt-enable mask and a fixed implementation identifier. Software reaches these registers through a simple CSR port.

When the pipeline takes a trap, the unit stacks the enable and privilege state and saves the faulting PC. It records the cause: for an exception it picks the highest-priority code from the set of exceptions raised, and for an interrupt it sets the top bit. It also produces the address to fetch from next. On a trap return it unwinds the stack and redirects fetch to the saved PC. While reset is held it asks fetch to start at a fixed reset vector.

An optional user mode, chosen by a parameter, adds a second privilege level. It also makes the prior-privilege field and the data-privilege-override bit writable.

Top module: `mstat_trap_unit`

## Requirements
- R1: While `rst` is high, `redirect_o` is 1 and `redirect_pc_o` equals `RESET_VEC`. After reset, status, cause, interrupt enables, vector base and saved PC read 0, except the prior-privilege field, which reads 2'b11. `gie_o` is 0 and `priv_o` is 2'b11.
- R2: On a trap (`trap_i`=1), the following registers update at the next clock edge. The prior enable (status bit 7) takes the global enable (status bit 3). The global enable clears. The prior privilege (status bits 12:11) takes the current privilege, and the current privilege becomes 2'b11.
- R3: On a trap return (`mret_i`=1 without `trap_i`), the global enable takes the prior enable, and the prior enable becomes 1. The current privilege takes the prior privilege, and the prior privilege becomes 2'b11. If the return goes to user mode (2'b00), the override bit (status bit 17) clears.
- R4: The implementation identifier at address 0xF13 always reads 0, and writes to it have no effect.
- R5: In the status register only bits 3, 7, 12:11 and 17 can ever read nonzero. The extension-state field (bits 16:15) and the byte-order bit (bit 6) are read-only zero.
- R6: An interrupt-enable bit (address 0x304) is writable only where `IRQ_MASK` is 1. All other bits read 0 and ignore writes.
- R7: For an exception trap, the cause holds the highest-priority code set in `trap_exc_i`, which is indexed by code. The order from highest to lowest is 3, 12, 1, 2, 0, 8, 9, 11, 15, 13, 7, 5, 6, 4. Codes 10 and 14 do not exist.
- R8: A load access fault (5) outranks a load misaligned fault (4), and a store access fault (7) outranks a store misaligned fault (6).
- R9: For an interrupt trap, the cause (address 0x342) reads bit 31 set and bits 4:0 equal to `trap_irq_code_i`. The saved PC (address 0x341) captures `trap_pc_i` with bits 1:0 cleared.
- R10: In the cycle of a trap, `redirect_pc_o` is the vector base (address 0x305, bits 31:2). It becomes base + 4*code when vector bit 0 is 1 and the trap is an interrupt. In the cycle of a trap return it is the saved PC. `redirect_o` is 1 in both cases.
- R11: A trap takes precedence over a trap return and over a CSR write in the same cycle. A trap return also drops a CSR write in the same cycle.
- R12: With user mode enabled, a prior-privilege write keeps only 2'b00 or 2'b11, and any other value leaves the field unchanged. Without user mode the field stays 2'b11 and bit 17 stays 0.
- R13: Reads of any address other than 0x300, 0x304, 0x305, 0x341, 0x342 and 0xF13 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_en_i | input | 1 | CSR access enable |
| csr_we_i | input | 1 | CSR write strobe (with enable) |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data (0 when not enabled) |
| trap_i | input | 1 | Trap taken strobe |
| trap_irq_i | input | 1 | Trap is an interrupt |
| trap_irq_code_i | input | 5 | Interrupt code |
| trap_exc_i | input | 16 | Raised synchronous exceptions, one bit per code |
| trap_pc_i | input | 32 | PC of the trapping instruction |
| mret_i | input | 1 | Trap return strobe |
| redirect_o | output | 1 | Fetch redirect request |
| redirect_pc_o | output | 32 | Fetch redirect target |
| gie_o | output | 1 | Global interrupt enable |
| priv_o | output | 2 | Current privilege level |

## Verification
The bench builds the unit with `SUPPORT_USER`=1 and `IRQ_MASK`=32'h0001_0888, keeping the default reset vector. User mode makes returns to privilege 2'b00 possible. It also makes the override-bit clearing and the prior-privilege legalisation observable. The sparse mask, which includes a high platform bit, exposes any writable bit that falls outside the mask. A random mix of writes, interrupt and exception traps with random exception sets, and returns drives a model whose register values are compared after each step. Directed cases cover the paired-fault priority and collisions between trap, return and write.

// File: rtl/mstat_pkg.sv
package mstat_pkg;

    localparam int XLEN = 32;
    localparam int EXC_W = 16;
    localparam int NUM_RANK = 14;

    localparam logic [11:0] A_STATUS = 12'h300;
    localparam logic [11:0] A_IEN    = 12'h304;
    localparam logic [11:0] A_TVEC   = 12'h305;
    localparam logic [11:0] A_EPC    = 12'h341;
    localparam logic [11:0] A_CAUSE  = 12'h342;
    localparam logic [11:0] A_IMPL   = 12'hF13;

    localparam int B_GIE  = 3;
    localparam int B_PGIE = 7;
    localparam int B_PPL  = 11;
    localparam int B_DPO  = 17;

    typedef enum logic [1:0] {
        PRIV_USER = 2'b00,
        PRIV_MACH = 2'b11
    } priv_e;

    typedef struct packed {
        logic  dpo;
        priv_e ppriv;
        logic  pgie;
        logic  gie;
    } stat_t;

    typedef struct packed {
        logic       found;
        logic [3:0] code;
    } exc_pick_t;

    // Exception code held at each priority rank, rank 0 highest.
    function automatic logic [3:0] rank_code(int unsigned rank);
        case (rank)
            0:  return 4'd3;
            1:  return 4'd12;
            2:  return 4'd1;
            3:  return 4'd2;
            4:  return 4'd0;
            5:  return 4'd8;
            6:  return 4'd9;
            7:  return 4'd11;
            8:  return 4'd15;
            9:  return 4'd13;
            10: return 4'd7;
            11: return 4'd5;
            12: return 4'd6;
            13: return 4'd4;
            default: return 4'd0;
        endcase
    endfunction

    function automatic exc_pick_t pick_exc(logic [EXC_W-1:0] raised);
        exc_pick_t r;
        r.found = 1'b0;
        r.code  = 4'd0;
        for (int unsigned k = 0; k < NUM_RANK; k++) begin
            if (!r.found && raised[rank_code(k)]) begin
                r.found = 1'b1;
                r.code  = rank_code(k);
            end
        end
        return r;
    endfunction

    function automatic logic [XLEN-1:0] pack_status(stat_t s);
        logic [XLEN-1:0] v;
        v = '0;
        v[B_GIE]           = s.gie;
        v[B_PGIE]          = s.pgie;
        v[B_PPL+1:B_PPL]   = s.ppriv;
        v[B_DPO]           = s.dpo;
        return v;
    endfunction

endpackage

// File: rtl/mstat_exc_select.sv
module mstat_exc_select
    import mstat_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                trap_i,
    input  logic                irq_i,
    input  logic [4:0]          irq_code_i,
    input  logic [EXC_W-1:0]    exc_i,
    output logic [XLEN-1:0]     cause_o
);
    exc_pick_t pick;

    always_comb begin
        pick    = pick_exc(exc_i);
        cause_o = '0;
        if (irq_i) begin
            cause_o[XLEN-1] = 1'b1;
            cause_o[4:0]    = irq_code_i;
        end else begin
            cause_o[3:0]    = pick.code;
        end
    end

    // R7: the reported code is one of the raised exceptions
    p_pick_raised_r7: assert property (@(posedge clk) disable iff (rst)
        (trap_i && !irq_i && exc_i != '0) |-> exc_i[cause_o[3:0]]);

    // R8: access faults beat misaligned faults
    p_load_order_r8: assert property (@(posedge clk) disable iff (rst)
        (trap_i && !irq_i && exc_i[5]) |-> (cause_o[4:0] != 5'd4));
    p_store_order_r8: assert property (@(posedge clk) disable iff (rst)
        (trap_i && !irq_i && exc_i[7]) |-> (cause_o[4:0] != 5'd6));
endmodule

// File: rtl/mstat_status_unit.sv
module mstat_status_unit
    import mstat_pkg::*;
#(
    parameter bit SUPPORT_USER = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trap_fire_i,
    input  logic            mret_fire_i,
    input  logic            wr_fire_i,
    input  logic [XLEN-1:0] wdata_i,
    output stat_t           stat_o,
    output priv_e           priv_o
);
    stat_t  st_q;
    priv_e  priv_q;
    priv_e  ppriv_wr;
    logic   dpo_wr;
    logic [1:0] ppl_w;

    assign ppl_w = wdata_i[B_PPL+1:B_PPL];

    generate
        if (SUPPORT_USER) begin : g_user
            always_comb begin
                if (ppl_w == 2'b00)      ppriv_wr = PRIV_USER;
                else if (ppl_w == 2'b11) ppriv_wr = PRIV_MACH;
                else                     ppriv_wr = st_q.ppriv;
                dpo_wr = wdata_i[B_DPO];
            end
        end else begin : g_mach_only
            always_comb begin
                ppriv_wr = PRIV_MACH;
                dpo_wr   = 1'b0 & ^wdata_i;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.gie   <= 1'b0;
            st_q.pgie  <= 1'b0;
            st_q.ppriv <= PRIV_MACH;
            st_q.dpo   <= 1'b0;
            priv_q     <= PRIV_MACH;
        end else if (trap_fire_i) begin
            st_q.pgie  <= st_q.gie;
            st_q.gie   <= 1'b0;
            st_q.ppriv <= priv_q;
            priv_q     <= PRIV_MACH;
        end else if (mret_fire_i) begin
            st_q.gie   <= st_q.pgie;
            st_q.pgie  <= 1'b1;
            priv_q     <= st_q.ppriv;
            st_q.ppriv <= PRIV_MACH;
            if (st_q.ppriv != PRIV_MACH) st_q.dpo <= 1'b0;
        end else if (wr_fire_i) begin
            st_q.gie   <= wdata_i[B_GIE];
            st_q.pgie  <= wdata_i[B_PGIE];
            st_q.ppriv <= ppriv_wr;
            st_q.dpo   <= dpo_wr;
        end
    end

    assign stat_o = st_q;
    assign priv_o = priv_q;

    p_trap_gie_r2: assert property (@(posedge clk) disable iff (rst)
        trap_fire_i |=> (!stat_o.gie && stat_o.pgie == $past(stat_o.gie)));
    p_trap_priv_r2: assert property (@(posedge clk) disable iff (rst)
        trap_fire_i |=> (priv_o == PRIV_MACH && stat_o.ppriv == $past(priv_o)));
    p_mret_gie_r3: assert property (@(posedge clk) disable iff (rst)
        mret_fire_i |=> (stat_o.pgie && stat_o.gie == $past(stat_o.pgie)));
    p_mret_dpo_r3: assert property (@(posedge clk) disable iff (rst)
        (mret_fire_i && stat_o.ppriv == PRIV_USER) |=> !stat_o.dpo);
endmodule

// File: rtl/mstat_trap_state.sv
module mstat_trap_state
    import mstat_pkg::*;
#(
    parameter logic [XLEN-1:0] IRQ_MASK = 32'h0000_0888
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trap_fire_i,
    input  logic [XLEN-1:0] trap_pc_i,
    input  logic [XLEN-1:0] trap_cause_i,
    input  logic            wr_ien_i,
    input  logic            wr_tvec_i,
    input  logic            wr_epc_i,
    input  logic            wr_cause_i,
    input  logic [XLEN-1:0] wdata_i,
    output logic [XLEN-1:0] ien_o,
    output logic [XLEN-1:0] tvec_o,
    output logic [XLEN-1:0] epc_o,
    output logic [XLEN-1:0] cause_o
);
    localparam logic [XLEN-1:0] TVEC_KEEP  = ~(XLEN'(2));
    localparam logic [XLEN-1:0] EPC_KEEP   = ~(XLEN'(3));
    localparam logic [XLEN-1:0] CAUSE_KEEP = {1'b1, {(XLEN-6){1'b0}}, 5'h1F};

    logic [XLEN-1:0] ien_q, tvec_q, epc_q, cause_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q   <= '0;
            tvec_q  <= '0;
            epc_q   <= '0;
            cause_q <= '0;
        end else if (trap_fire_i) begin
            epc_q   <= trap_pc_i & EPC_KEEP;
            cause_q <= trap_cause_i;
        end else begin
            if (wr_ien_i)   ien_q   <= wdata_i & IRQ_MASK;
            if (wr_tvec_i)  tvec_q  <= wdata_i & TVEC_KEEP;
            if (wr_epc_i)   epc_q   <= wdata_i & EPC_KEEP;
            if (wr_cause_i) cause_q <= wdata_i & CAUSE_KEEP;
        end
    end

    assign ien_o   = ien_q;
    assign tvec_o  = tvec_q;
    assign epc_o   = epc_q;
    assign cause_o = cause_q;

    p_epc_aligned_r9: assert property (@(posedge clk) disable iff (rst)
        epc_o[1:0] == 2'b00);
    p_ien_masked_r6: assert property (@(posedge clk) disable iff (rst)
        (ien_o & ~IRQ_MASK) == '0);
    p_trap_epc_r11: assert property (@(posedge clk) disable iff (rst)
        trap_fire_i |=> epc_o[XLEN-1:2] == $past(trap_pc_i[XLEN-1:2]));
endmodule

// File: rtl/mstat_trap_unit.sv
module mstat_trap_unit
    import mstat_pkg::*;
#(
    parameter logic [31:0] RESET_VEC    = 32'h8000_0000,
    parameter logic [31:0] IRQ_MASK     = 32'h0000_0888,
    parameter bit          SUPPORT_USER = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        csr_en_i,
    input  logic        csr_we_i,
    input  logic [11:0] csr_addr_i,
    input  logic [31:0] csr_wdata_i,
    output logic [31:0] csr_rdata_o,
    input  logic        trap_i,
    input  logic        trap_irq_i,
    input  logic [4:0]  trap_irq_code_i,
    input  logic [15:0] trap_exc_i,
    input  logic [31:0] trap_pc_i,
    input  logic        mret_i,
    output logic        redirect_o,
    output logic [31:0] redirect_pc_o,
    output logic        gie_o,
    output logic [1:0]  priv_o
);
    logic            mret_fire, wr_fire;
    logic [XLEN-1:0] cause_new, ien, tvec, epc, cause;
    logic [XLEN-1:0] vec_tgt;
    stat_t           stat;
    priv_e           priv;

    assign mret_fire = mret_i & ~trap_i;
    assign wr_fire   = csr_en_i & csr_we_i & ~trap_i & ~mret_i;

    mstat_exc_select u_sel (
        .clk        (clk),
        .rst        (rst),
        .trap_i     (trap_i),
        .irq_i      (trap_irq_i),
        .irq_code_i (trap_irq_code_i),
        .exc_i      (trap_exc_i),
        .cause_o    (cause_new)
    );

    mstat_status_unit #(.SUPPORT_USER(SUPPORT_USER)) u_stat (
        .clk         (clk),
        .rst         (rst),
        .trap_fire_i (trap_i),
        .mret_fire_i (mret_fire),
        .wr_fire_i   (wr_fire && csr_addr_i == A_STATUS),
        .wdata_i     (csr_wdata_i),
        .stat_o      (stat),
        .priv_o      (priv)
    );

    mstat_trap_state #(.IRQ_MASK(IRQ_MASK)) u_state (
        .clk          (clk),
        .rst          (rst),
        .trap_fire_i  (trap_i),
        .trap_pc_i    (trap_pc_i),
        .trap_cause_i (cause_new),
        .wr_ien_i     (wr_fire && csr_addr_i == A_IEN),
        .wr_tvec_i    (wr_fire && csr_addr_i == A_TVEC),
        .wr_epc_i     (wr_fire && csr_addr_i == A_EPC),
        .wr_cause_i   (wr_fire && csr_addr_i == A_CAUSE),
        .wdata_i      (csr_wdata_i),
        .ien_o        (ien),
        .tvec_o       (tvec),
        .epc_o        (epc),
        .cause_o      (cause)
    );

    always_comb begin
        csr_rdata_o = '0;
        if (csr_en_i) begin
            case (csr_addr_i)
                A_STATUS: csr_rdata_o = pack_status(stat);
                A_IEN:    csr_rdata_o = ien;
                A_TVEC:   csr_rdata_o = tvec;
                A_EPC:    csr_rdata_o = epc;
                A_CAUSE:  csr_rdata_o = cause;
                A_IMPL:   csr_rdata_o = '0;
                default:  csr_rdata_o = '0;
            endcase
        end
    end

    always_comb begin
        vec_tgt = {tvec[XLEN-1:2], 2'b00};
        if (tvec[0] && trap_irq_i)
            vec_tgt = vec_tgt + {{(XLEN-7){1'b0}}, trap_irq_code_i, 2'b00};
    end

    assign redirect_o    = rst | trap_i | mret_i;
    assign redirect_pc_o = rst ? RESET_VEC : (trap_i ? vec_tgt : epc);
    assign gie_o         = stat.gie;
    assign priv_o        = priv;

    p_mret_target_r10: assert property (@(posedge clk) disable iff (rst)
        (mret_i && !trap_i) |-> (redirect_o && redirect_pc_o == epc));
    p_trap_wins_r11: assert property (@(posedge clk) disable iff (rst)
        (trap_i && mret_i) |=> !gie_o);
endmodule

// File: tb/mstat_trap_unit_bench.sv
module mstat_trap_unit_bench;
    localparam int CLK_P = 10;
    localparam logic [31:0] MASK = 32'h0001_0888;
    localparam logic [31:0] RVEC = 32'h8000_0000;

    logic clk = 0, rst = 1;
    logic csr_en = 0, csr_we = 0;
    logic [11:0] csr_addr = 0;
    logic [31:0] csr_wdata = 0, csr_rdata;
    logic trap = 0, trap_irq = 0, mret = 0;
    logic [4:0] irq_code = 0;
    logic [15:0] exc = 0;
    logic [31:0] tpc = 0;
    logic redirect, gie;
    logic [31:0] redirect_pc;
    logic [1:0] priv;

    int n_cmp = 0, n_bad = 0;

    // model state
    logic m_gie, m_pgie, m_dpo;
    logic [1:0] m_ppriv, m_priv;
    logic [31:0] m_ien, m_tvec, m_epc, m_cause;

    always #(CLK_P/2) clk = ~clk;

    mstat_trap_unit #(.RESET_VEC(RVEC), .IRQ_MASK(MASK), .SUPPORT_USER(1'b1)) u_mstat_trap_unit (
        .clk(clk), .rst(rst), .csr_en_i(csr_en), .csr_we_i(csr_we),
        .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata),
        .trap_i(trap), .trap_irq_i(trap_irq), .trap_irq_code_i(irq_code),
        .trap_exc_i(exc), .trap_pc_i(tpc), .mret_i(mret),
        .redirect_o(redirect), .redirect_pc_o(redirect_pc),
        .gie_o(gie), .priv_o(priv)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] best_exc(input logic [15:0] v);
        int unsigned order [14] = '{3, 12, 1, 2, 0, 8, 9, 11, 15, 13, 7, 5, 6, 4};
        for (int k = 0; k < 14; k++)
            if (v[order[k]]) return 4'(order[k]);
        return 4'd0;
    endfunction

    function automatic logic [31:0] m_status();
        return (32'(m_dpo) << 17) | (32'(m_ppriv) << 11) | (32'(m_pgie) << 7) | (32'(m_gie) << 3);
    endfunction

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        csr_en = 1; csr_we = 0; csr_addr = a;
        #1 chk(tag, csr_rdata, exp);
        csr_en = 0;
    endtask

    task automatic check_all(input string ctx);
        rd(12'h300, m_status(), {ctx, " R2/R3/R5 status"});
        rd(12'h304, m_ien,      {ctx, " R6 ien"});
        rd(12'h305, m_tvec,     {ctx, " R10 tvec"});
        rd(12'h341, m_epc,      {ctx, " R9 epc"});
        rd(12'h342, m_cause,    {ctx, " R7/R9 cause"});
        rd(12'hF13, 32'h0,      {ctx, " R4 impl"});
        chk({ctx, " R2/R3 gie_o"}, 32'(gie), 32'(m_gie));
        chk({ctx, " R2/R3 priv_o"}, 32'(priv), 32'(m_priv));
    endtask

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        case (a)
            12'h300: begin
                m_gie = d[3]; m_pgie = d[7]; m_dpo = d[17];
                if (d[12:11] == 2'b00 || d[12:11] == 2'b11) m_ppriv = d[12:11];
            end
            12'h304: m_ien = d & MASK;
            12'h305: m_tvec = d & 32'hFFFF_FFFD;
            12'h341: m_epc = d & 32'hFFFF_FFFC;
            12'h342: m_cause = d & 32'h8000_001F;
            default: ;
        endcase
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_en = 1; csr_we = 1; csr_addr = a; csr_wdata = d;
        @(posedge clk); #1;
        csr_en = 0; csr_we = 0;
        model_write(a, d);
    endtask

    // trap with optional same-cycle write and return
    task automatic do_trap(input logic irq, input logic [4:0] code, input logic [15:0] v,
                           input logic [31:0] pc, input logic with_wr, input logic with_mret);
        logic [31:0] tgt;
        @(negedge clk);
        trap = 1; trap_irq = irq; irq_code = code; exc = v; tpc = pc; mret = with_mret;
        if (with_wr) begin csr_en = 1; csr_we = 1; csr_addr = 12'h300; csr_wdata = 32'hFFFF_FFFF; end
        tgt = {m_tvec[31:2], 2'b00};
        if (m_tvec[0] && irq) tgt = tgt + {25'b0, code, 2'b00};
        #1;
        chk("R10 trap redirect", 32'(redirect), 32'd1);
        chk("R10 trap target", redirect_pc, tgt);
        @(posedge clk); #1;
        trap = 0; mret = 0; csr_en = 0; csr_we = 0;
        m_pgie = m_gie; m_gie = 0; m_ppriv = m_priv; m_priv = 2'b11;
        m_epc = pc & 32'hFFFF_FFFC;
        m_cause = irq ? {1'b1, 26'b0, code} : {28'b0, best_exc(v)};
    endtask

    task automatic do_mret(input logic with_wr);
        @(negedge clk);
        mret = 1;
        if (with_wr) begin csr_en = 1; csr_we = 1; csr_addr = 12'h304; csr_wdata = 32'hFFFF_FFFF; end
        #1;
        chk("R10 mret redirect", 32'(redirect), 32'd1);
        chk("R10 mret target", redirect_pc, m_epc);
        @(posedge clk); #1;
        mret = 0; csr_en = 0; csr_we = 0;
        m_gie = m_pgie; m_pgie = 1;
        if (m_ppriv != 2'b11) m_dpo = 0;
        m_priv = m_ppriv; m_ppriv = 2'b11;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int unsigned dummy;
        dummy = $urandom(32'h5EED_0042);
        m_gie = 0; m_pgie = 0; m_dpo = 0; m_ppriv = 2'b11; m_priv = 2'b11;
        m_ien = 0; m_tvec = 0; m_epc = 0; m_cause = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset redirect", 32'(redirect), 32'd1);
        chk("R1 reset vector", redirect_pc, RVEC);
        rst = 0;
        check_all("R1 after reset");

        // R4 / R5 / R6 / R13
        wr(12'hF13, 32'hDEAD_BEEF);
        rd(12'hF13, 32'h0, "R4 impl after write");
        wr(12'h300, 32'hFFFF_FFFF);
        rd(12'h300, 32'h0002_1888, "R5 status all-ones write");
        wr(12'h304, 32'hFFFF_FFFF);
        rd(12'h304, MASK, "R6 ien all-ones write");
        rd(12'h123, 32'h0, "R13 unmapped read");
        rd(12'h301, 32'h0, "R13 unmapped read near status");

        // R12: illegal prior privilege keeps old value
        wr(12'h300, 32'h0000_0000);
        wr(12'h300, 32'h0000_0800);
        rd(12'h300, 32'h0, "R12 illegal ppriv ignored");
        check_all("R12");

        // R3: return to user clears override bit
        wr(12'h341, 32'h0000_1003);
        wr(12'h300, 32'h0002_0080);
        do_mret(1'b0);
        check_all("R3 return to user");
        chk("R3 priv user", 32'(priv), 32'd0);

        // R2: trap from user
        do_trap(1'b0, 5'd0, 16'h0004, 32'h0000_2002, 1'b0, 1'b0);
        check_all("R2 trap from user");

        // R8 / R7 directed priority
        do_trap(1'b0, 5'd0, 16'h0030, 32'h100, 1'b0, 1'b0);
        rd(12'h342, 32'd5, "R8 load access over misaligned");
        do_trap(1'b0, 5'd0, 16'h00C0, 32'h104, 1'b0, 1'b0);
        rd(12'h342, 32'd7, "R8 store access over misaligned");
        do_trap(1'b0, 5'd0, 16'h1008, 32'h108, 1'b0, 1'b0);
        rd(12'h342, 32'd3, "R7 code 3 over 12");
        do_trap(1'b0, 5'd0, 16'hA000, 32'h10C, 1'b0, 1'b0);
        rd(12'h342, 32'd15, "R7 code 15 over 13");

        // R10 vectored interrupt, R9 cause
        wr(12'h305, 32'h0000_4001);
        do_trap(1'b1, 5'd11, 16'h0, 32'h0000_3007, 1'b0, 1'b0);
        check_all("R9 R10 vectored irq");
        do_trap(1'b0, 5'd0, 16'h0100, 32'h200, 1'b0, 1'b0);
        check_all("R10 vectored exception uses base");

        // R11 collisions
        wr(12'h300, 32'h0000_0088);
        do_trap(1'b1, 5'd7, 16'h0, 32'h300, 1'b1, 1'b1);
        check_all("R11 trap beats write and mret");
        do_mret(1'b1);
        check_all("R11 mret drops write");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int unsigned op = $urandom_range(0, 9);
            if (op < 4) begin
                logic [11:0] a;
                int unsigned s = $urandom_range(0, 6);
                case (s)
                    0: a = 12'h300; 1: a = 12'h304; 2: a = 12'h305;
                    3: a = 12'h341; 4: a = 12'h342; 5: a = 12'hF13;
                    default: a = 12'h7C0;
                endcase
                wr(a, $urandom);
            end else if (op < 7) begin
                logic [15:0] v = 16'($urandom) & 16'hBBFF;
                if (v == 0) v = 16'h0004;
                do_trap(op == 6, 5'($urandom), v, $urandom, 1'($urandom), 1'($urandom));
            end else begin
                do_mret(1'($urandom));
            end
            check_all("R7 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule